// File: doc/BRIEF.md
# Multi-Cycle 32-Bit Load/Store Processor Core

This block is a small 32-bit processor core. It runs each instruction as a sequence of short clock phases instead of one long cycle. One adder/logic unit and one word-wide memory port are shared by all phases. Instruction fetch and data access use the same memory. Between phases, values are kept in a small set of internal registers: the program counter, the instruction register, two operand latches, a result latch and a memory-data latch.

The core implements five instruction classes:
- three-register arithmetic and logic;
- word load;
- word store;
- branch when two registers are equal;
- absolute jump inside the current 256 MB region.

The branch target is computed early, in the decode phase, while the arithmetic unit would otherwise sit idle. It is held in the result latch until the branch phase decides whether to use it.

The surrounding system attaches a word-addressed memory with combinational read and synchronous write. It can watch the program counter and the phase code on the debug outputs.

Top module: `mc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `dbg_state` = 0 (fetch), `dbg_pc` = 0x00400000 and `mem_we` = 0.
- R2: Phase codes on `dbg_state`: 0 fetch, 1 decode, 2 address, 3 load-read, 4 load-writeback, 5 store, 6 execute, 7 arithmetic-writeback, 8 branch, 9 jump. In fetch, the word at the PC is taken as the instruction and the PC becomes PC+4 at the same edge. Decode always follows fetch.
- R3: Instruction fields are: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], function [5:0], immediate [15:0]. Opcode 0x00 writes rd with rs op rt, where the function code selects the operation: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x2A signed set-less-than. It takes 4 cycles.
- R4: Opcode 0x23 loads rt from the word at rs + sign-extended immediate. It takes 5 cycles, and the load-read phase is followed by load-writeback.
- R5: Opcode 0x2B writes rt to the word at rs + sign-extended immediate. It takes 4 cycles.
- R6: Opcode 0x04 takes 3 cycles. When rs equals rt, the PC becomes (fetch PC + 4) + (sign-extended immediate × 4); otherwise the PC stays at fetch PC + 4. The PC changes in no phase other than fetch, branch and jump.
- R7: Opcode 0x02 sets the PC to {PC[31:28], instr[25:0], 2'b00} and takes 3 cycles.
- R8: Register 0 reads as zero. A write to it is discarded.
- R9: Any other opcode goes back to fetch right after decode (2 cycles). It changes no register and no memory.
- R10: `mem_addr` carries byte-address bits [ADDR_W+1:2]: the PC's bits during fetch and the computed address during load-read and store. `mem_we` is high only in the store phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | ADDR_W | Word address to the unified memory |
| mem_wdata | output | 32 | Store data |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | 32 | Word read from `mem_addr` (combinational) |
| dbg_pc | output | 32 | Current program counter |
| dbg_state | output | 4 | Current phase code |

## Verification
Two actions share the branch phase. The equality compare overwrites the result latch, and at the same edge the PC may be loaded from the old value of that latch, which holds the target computed during decode. The bench places taken and not-taken branches, both directed and random, among arithmetic, load and store traffic. At the following fetch it compares the program counter and the cycle count with a bench model. Final memory contents, including a dump of every register, show whether a taken branch skipped the instruction it jumped over.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int XLEN = 32;

  localparam logic [5:0] OPC_ARITH = 6'h00;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_JMP   = 6'h02;

  typedef enum logic [3:0] {
    ST_FETCH  = 4'd0,
    ST_DECODE = 4'd1,
    ST_ADDR   = 4'd2,
    ST_LDRD   = 4'd3,
    ST_LDWB   = 4'd4,
    ST_STORE  = 4'd5,
    ST_EXEC   = 4'd6,
    ST_ARWB   = 4'd7,
    ST_BRANCH = 4'd8,
    ST_JUMP   = 4'd9
  } phase_t;

  typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT} alu_op_t;
  typedef enum logic [1:0] {BSEL_FOUR, BSEL_REG, BSEL_IMM, BSEL_OFS} bsel_t;
  typedef enum logic [1:0] {PSEL_ALU, PSEL_LATCH, PSEL_JMP} psel_t;

  typedef struct packed {
    logic    pc_we;
    psel_t   pc_sel;
    logic    ir_we;
    logic    a_is_pc;
    bsel_t   b_sel;
    alu_op_t alu_op;
    logic    addr_from_latch;
    logic    mem_we;
    logic    rf_we;
    logic    rf_from_mdr;
  } ctrl_t;
endpackage

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int W = XLEN
) (
  input  alu_op_t      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    unique case (op)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] raddr_a,
  input  logic [IW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we && waddr != '0) cells[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata_a <= (raddr_a == '0) ? '0 : cells[raddr_a];
    rdata_b <= (raddr_b == '0) ? '0 : cells[raddr_b];
  end
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  input  logic       alu_zero,
  output phase_t     phase,
  output ctrl_t      ctl
);
  phase_t nxt;

  function automatic alu_op_t funct_to_op(input logic [5:0] f);
    case (f)
      6'h22:   return ALU_SUB;
      6'h24:   return ALU_AND;
      6'h25:   return ALU_OR;
      6'h2A:   return ALU_SLT;
      default: return ALU_ADD;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) phase <= ST_FETCH;
    else     phase <= nxt;
  end

  always_comb begin
    ctl        = '0;
    ctl.alu_op = ALU_ADD;
    ctl.b_sel  = BSEL_REG;
    ctl.pc_sel = PSEL_ALU;
    nxt        = ST_FETCH;
    case (phase)
      ST_FETCH: begin
        ctl.pc_we   = 1'b1;
        ctl.ir_we   = 1'b1;
        ctl.a_is_pc = 1'b1;
        ctl.b_sel   = BSEL_FOUR;
        nxt         = ST_DECODE;
      end
      ST_DECODE: begin
        ctl.a_is_pc = 1'b1;
        ctl.b_sel   = BSEL_OFS;
        case (opcode)
          OPC_ARITH:           nxt = ST_EXEC;
          OPC_LOAD, OPC_STORE: nxt = ST_ADDR;
          OPC_BEQ:             nxt = ST_BRANCH;
          OPC_JMP:             nxt = ST_JUMP;
          default:             nxt = ST_FETCH;
        endcase
      end
      ST_ADDR: begin
        ctl.b_sel = BSEL_IMM;
        nxt = (opcode == OPC_LOAD) ? ST_LDRD : ST_STORE;
      end
      ST_LDRD: begin
        ctl.addr_from_latch = 1'b1;
        nxt = ST_LDWB;
      end
      ST_LDWB: begin
        ctl.rf_we       = 1'b1;
        ctl.rf_from_mdr = 1'b1;
      end
      ST_STORE: begin
        ctl.addr_from_latch = 1'b1;
        ctl.mem_we          = 1'b1;
      end
      ST_EXEC: begin
        ctl.alu_op = funct_to_op(funct);
        nxt = ST_ARWB;
      end
      ST_ARWB:   ctl.rf_we = 1'b1;
      ST_BRANCH: begin
        ctl.alu_op = ALU_SUB;
        ctl.pc_we  = alu_zero;
        ctl.pc_sel = PSEL_LATCH;
      end
      ST_JUMP: begin
        ctl.pc_we  = 1'b1;
        ctl.pc_sel = PSEL_JMP;
      end
      default: nxt = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter int          ADDR_W   = 10,
  parameter logic [31:0] RESET_PC = 32'h0040_0000
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic              mem_we,
  input  logic [31:0]       mem_rdata,
  output logic [31:0]       dbg_pc,
  output logic [3:0]        dbg_state
);
  localparam int NREG = 32;

  logic [XLEN-1:0] pc, ir, res_q, mdr_q, opa_q, opb_q;
  logic [XLEN-1:0] alu_a, alu_b, alu_y, simm;
  logic            alu_zero;
  phase_t          phase;
  ctrl_t           ctl;

  assign simm = {{16{ir[15]}}, ir[15:0]};

  mc_ctrl u_ctrl (
    .clk(clk), .rst(rst), .opcode(ir[31:26]), .funct(ir[5:0]),
    .alu_zero(alu_zero), .phase(phase), .ctl(ctl)
  );

  mc_regfile #(.W(XLEN), .DEPTH(NREG)) u_rf (
    .clk(clk),
    .we(ctl.rf_we),
    .waddr(ctl.rf_from_mdr ? ir[20:16] : ir[15:11]),
    .wdata(ctl.rf_from_mdr ? mdr_q : res_q),
    .raddr_a(ir[25:21]),
    .raddr_b(ir[20:16]),
    .rdata_a(opa_q),
    .rdata_b(opb_q)
  );

  assign alu_a = ctl.a_is_pc ? pc : opa_q;
  always_comb begin
    case (ctl.b_sel)
      BSEL_FOUR: alu_b = 32'd4;
      BSEL_IMM:  alu_b = simm;
      BSEL_OFS:  alu_b = {simm[29:0], 2'b00};
      default:   alu_b = opb_q;
    endcase
  end

  mc_alu #(.W(XLEN)) u_alu (
    .op(ctl.alu_op), .a(alu_a), .b(alu_b), .y(alu_y), .zero(alu_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= RESET_PC;
      ir    <= '0;
      res_q <= '0;
      mdr_q <= '0;
    end else begin
      res_q <= alu_y;
      mdr_q <= mem_rdata;
      if (ctl.ir_we) ir <= mem_rdata;
      if (ctl.pc_we) begin
        case (ctl.pc_sel)
          PSEL_LATCH: pc <= res_q;
          PSEL_JMP:   pc <= {pc[31:28], ir[25:0], 2'b00};
          default:    pc <= alu_y;
        endcase
      end
    end
  end

  assign mem_addr  = ctl.addr_from_latch ? res_q[ADDR_W+1:2] : pc[ADDR_W+1:2];
  assign mem_wdata = opb_q;
  assign mem_we    = ctl.mem_we;
  assign dbg_pc    = pc;
  assign dbg_state = phase;
endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk #(
  parameter logic [31:0] RESET_PC = 32'h0040_0000
) (
  input logic        clk,
  input logic        rst,
  input logic        mem_we,
  input logic [31:0] dbg_pc,
  input logic [3:0]  dbg_state
);
  assert_reset_vec_R1: assert property (@(posedge clk)
    rst |=> (dbg_state == 4'd0 && dbg_pc == RESET_PC && !mem_we));

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    dbg_state == 4'd0 |=> dbg_pc == $past(dbg_pc) + 32'd4);

  assert_decode_next_R2: assert property (@(posedge clk) disable iff (rst)
    dbg_state == 4'd0 |=> dbg_state == 4'd1);

  assert_load_seq_R4: assert property (@(posedge clk) disable iff (rst)
    dbg_state == 4'd3 |=> dbg_state == 4'd4);

  assert_pc_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (dbg_state != 4'd0 && dbg_state != 4'd8 && dbg_state != 4'd9) |=> $stable(dbg_pc));

  assert_we_store_R10: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> dbg_state == 4'd5);

  assert_legal_phase_R2: assert property (@(posedge clk) disable iff (rst)
    dbg_state <= 4'd9);
endmodule

bind mc_core mc_core_chk #(.RESET_PC(RESET_PC)) u_chk (
  .clk(clk), .rst(rst), .mem_we(mem_we), .dbg_pc(dbg_pc), .dbg_state(dbg_state)
);

// File: tb/mc_core_tb_top.sv
module mc_core_tb_top;
  localparam int          ADDR_W   = 10;
  localparam int          DEPTH    = 1 << ADDR_W;
  localparam logic [31:0] RESET_PC = 32'h0040_0000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] mem_addr;
  logic [31:0]       mem_wdata, mem_rdata, dbg_pc;
  logic              mem_we;
  logic [3:0]        dbg_state;

  logic [31:0] mem     [DEPTH];
  logic [31:0] ref_mem [DEPTH];
  logic [31:0] ref_rf  [32];
  logic [31:0] ref_pc;
  int checks = 0, errors = 0, wp = 0, we_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mc_core #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) dut_i (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .dbg_pc(dbg_pc), .dbg_state(dbg_state)
  );

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input logic [4:0] rd, rs, rt, input logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs, rt,
                                        input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction
  function automatic logic [31:0] enc_j(input int idx);
    logic [31:0] t = (RESET_PC >> 2) + idx;
    return {6'h02, t[25:0]};
  endfunction

  task automatic emit(input logic [31:0] w);
    mem[wp] = w;
    ref_mem[wp] = w;
    wp++;
  endtask

  // Reference model: one instruction, returns expected cycles and tag
  task automatic ref_step(output int cyc, output string tag);
    logic [31:0] ins, simm, va, vb, ad, res, npc;
    ins  = ref_mem[ref_pc[ADDR_W+1:2]];
    simm = {{16{ins[15]}}, ins[15:0]};
    va   = ref_rf[ins[25:21]];
    vb   = ref_rf[ins[20:16]];
    ad   = va + simm;
    npc  = ref_pc + 32'd4;
    case (ins[31:26])
      6'h00: begin
        case (ins[5:0])
          6'h22:   res = va - vb;
          6'h24:   res = va & vb;
          6'h25:   res = va | vb;
          6'h2A:   res = {31'd0, $signed(va) < $signed(vb)};
          default: res = va + vb;
        endcase
        if (ins[15:11] != 5'd0) ref_rf[ins[15:11]] = res;
        cyc = 4; tag = "R3";
      end
      6'h23: begin
        if (ins[20:16] != 5'd0) ref_rf[ins[20:16]] = ref_mem[ad[ADDR_W+1:2]];
        cyc = 5; tag = "R4";
      end
      6'h2B: begin
        ref_mem[ad[ADDR_W+1:2]] = vb;
        cyc = 4; tag = "R5";
      end
      6'h04: begin
        if (va == vb) npc = npc + {simm[29:0], 2'b00};
        cyc = 3; tag = "R6";
      end
      6'h02: begin
        npc = {ref_pc[31:28], ins[25:0], 2'b00};
        cyc = 3; tag = "R7";
      end
      default: begin
        cyc = 2; tag = "R9";
      end
    endcase
    ref_pc = npc;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    int halt_idx, cyc, expc, n;
    string tag;
    logic [31:0] halt_pc;
    void'($urandom(32'd2024));
    for (int i = 0; i < DEPTH; i++) begin mem[i] = '0; ref_mem[i] = '0; end
    for (int i = 0; i < 32; i++) ref_rf[i] = '0;
    for (int i = 0; i < 64; i++) begin
      mem[512+i] = $urandom; ref_mem[512+i] = mem[512+i];
    end
    mem[513] = 32'd5; ref_mem[513] = 32'd5;
    mem[514] = 32'hFFFF_FFF0; ref_mem[514] = mem[514];
    // load every register (R4)
    for (int r = 1; r < 32; r++) emit(enc_i(6'h23, 5'd0, 5'(r), 16'(32'h800 + 4*r)));
    // directed corner cases
    emit(enc_i(6'h04, 5'd0, 5'd1, 16'd3));              // R6 not taken (r1=5)
    emit(enc_i(6'h04, 5'd2, 5'd2, 16'd1));              // R6 taken, skips next
    emit(enc_i(6'h2B, 5'd0, 5'd3, 16'h0900));           // skipped store
    emit(enc_j(wp + 2));                                // R7 skips next
    emit(enc_i(6'h2B, 5'd0, 5'd4, 16'h0904));           // skipped store
    emit(32'hFC00_FFFF);                                // R9 unknown opcode
    emit(enc_r(5'd0, 5'd1, 5'd2, 6'h20));               // R8 write to r0
    emit(enc_i(6'h2B, 5'd0, 5'd0, 16'h09F0));           // R8 store r0
    emit(enc_i(6'h2B, 5'd0, 5'd5, 16'hFFFC));           // negative offset
    emit(enc_i(6'h23, 5'd0, 5'd6, 16'hFFFC));
    emit(enc_r(5'd7, 5'd2, 5'd1, 6'h2A));               // slt with negative
    // constrained random block
    for (int k = 0; k < 60; k++) begin
      int sel = $urandom % 10;
      logic [5:0] fns [5] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2A};
      if (sel < 5)
        emit(enc_r(5'($urandom), 5'($urandom), 5'($urandom), fns[$urandom % 5]));
      else if (sel < 7)
        emit(enc_i(6'h23, 5'd0, 5'($urandom), 16'(32'h800 + 4*($urandom % 64))));
      else if (sel < 9)
        emit(enc_i(6'h2B, 5'd0, 5'($urandom), 16'(32'h800 + 4*($urandom % 64))));
      else
        emit(enc_i(6'h04, 5'($urandom % 4), 5'($urandom % 4), 16'd1));
    end
    // dump registers
    for (int r = 1; r < 32; r++) emit(enc_i(6'h2B, 5'd0, 5'(r), 16'(32'h900 + 4*r)));
    halt_idx = wp;
    emit(enc_j(halt_idx));
    halt_pc = RESET_PC + 32'(4*halt_idx);

    repeat (3) @(negedge clk);
    chk(dbg_state == 4'd0, "R1", "reset phase", 32'(dbg_state), 32'd0);
    chk(dbg_pc == RESET_PC, "R1", "reset pc", dbg_pc, RESET_PC);
    chk(!mem_we, "R1", "reset write strobe", 32'(mem_we), 32'd0);
    rst = 1'b0;
    ref_pc = RESET_PC;
    n = 0;
    while (ref_pc != halt_pc && n < 400) begin
      chk(dbg_state == 4'd0, "R2", "fetch phase", 32'(dbg_state), 32'd0);
      chk(dbg_pc == ref_pc, "R2", "pc at fetch", dbg_pc, ref_pc);
      chk(mem_addr == ref_pc[ADDR_W+1:2], "R10", "fetch address",
          32'(mem_addr), 32'(ref_pc[ADDR_W+1:2]));
      ref_step(expc, tag);
      cyc = 0;
      do begin
        @(negedge clk);
        cyc++;
        if (mem_we && dbg_state != 4'd5) we_bad++;
      end while (dbg_state != 4'd0 && cyc < 16);
      chk(cyc == expc, tag, "cycle count", 32'(cyc), 32'(expc));
      n++;
    end
    chk(dbg_pc == halt_pc, "R7", "final pc", dbg_pc, halt_pc);
    chk(we_bad == 0, "R10", "write strobe outside store", 32'(we_bad), 32'd0);
    chk(mem[636] == 32'd0, "R8", "stored r0", mem[636], 32'd0);
    for (int i = 0; i < DEPTH; i++)
      chk(mem[i] == ref_mem[i], "R5", $sformatf("memory word %0d (R3 R4 R6 R9)", i),
          mem[i], ref_mem[i]);
    done = 1;
    summary();
    $finish;
  end
endmodule